// File: doc/BRIEF.md
# Indexed Address Translation Window Unit

This block translates addresses through a small bank of programmable windows, four facing outbound and four facing inbound. Software never sees the windows side by side. It first writes a selector register to pick one window by direction and index. All later accesses to the shared window aperture then reach that window's base, limit, target and two control words. The register port is a plain 32-bit write strobe with a combinational read path.

A lookup request carries an address and a direction. The block captures it in a register and compares it with the enabled windows of that direction. One cycle later it returns one of three results: a translated memory address, a configuration-access descriptor (bus number, device/function number and offset inside the window), or a miss. Base, size, type and enable are kept as a committed copy. That copy is refreshed only when the second control word is written, so software can rewrite a window piece by piece without exposing a half-written window to traffic.

Top module: `xwu_top`

## Requirements
- R1: The selector register at offset 0x900 stores all 32 written bits and reads them back. Bits [3:0] pick the window index and bit 31 picks the direction (1 = inbound, 0 = outbound).
- R2: The window registers act on the selected window only: control word one at 0x904, control word two at 0x908, base low/high at 0x90C/0x910, 32-bit limit at 0x914, target low/high at 0x918/0x91C. Inbound and outbound windows with the same index are separate.
- R3: After reset every window reads base 0, target 0, limit 0xFFFFFFFF and control word one 0, and every control word two reads 0, except inbound window 0. That window reads 0x80000000 and is active, so inbound addresses 0 to 0xFFFFFFFF pass untranslated.
- R4: Writes to base, limit or control word one change what the registers read back, but leave matching unchanged until control word two of that window is written.
- R5: Writing control word two commits the window. Its bit 31 enables the window (1) or disables it (0).
- R6: A committed memory window matches an address A when A - base is below limit - base + 1 (64-bit arithmetic). It then outputs A - base + target.
- R7: A window committed while bits [4:0] of control word one are nonzero is a configuration window. A hit on it raises rsp_is_cfg, with rsp_bus = target[31:24], rsp_devfn = target[23:16] and rsp_addr = A - base.
- R8: When several enabled windows of the requested direction match, the lowest index wins.
- R9: A request that matches no enabled window gives rsp_miss = 1, rsp_hit = 0, rsp_is_cfg = 0 and zero address, bus, devfn and window outputs.
- R10: The response appears exactly one cycle after req_valid, for the address and direction captured with it. Back-to-back requests give back-to-back responses.
- R11: With a selected index of 4 or above, window register writes are ignored and reads return 0. Offsets outside the window aperture read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| req_valid | input | 1 | Lookup request valid |
| req_inbound | input | 1 | Lookup direction, 1 = inbound |
| req_addr | input | 64 | Address to translate |
| rsp_valid | output | 1 | Response valid, one cycle after request |
| rsp_hit | output | 1 | A window matched |
| rsp_miss | output | 1 | No window matched |
| rsp_is_cfg | output | 1 | Matched window is a configuration window |
| rsp_win | output | 2 | Index of the matching window |
| rsp_addr | output | 64 | Translated address or offset inside a configuration window |
| rsp_bus | output | 8 | Bus number for configuration hits |
| rsp_devfn | output | 8 | Device/function number for configuration hits |

## Verification
The hardest situation to reach is one where the readable registers and the committed match state disagree. That takes a window that was committed, then partly rewritten without a new commit. The stimulus commits a window, moves its base and limit through the aperture, and probes both the old and the new ranges before and after the commit write. Overlapping windows are built by committing a wide high-index window first and then a narrow low-index window over it. This exposes the priority order at addresses inside and just outside the narrow one.

// File: rtl/xwu_pkg.sv
package xwu_pkg;

    localparam int XW_DATA_W = 32;
    localparam int XW_ADDR_W = 64;
    localparam int XW_IDX_W  = 4;
    localparam int XW_TYPE_W = 5;

    localparam logic [11:0] OFF_VIEW   = 12'h900;
    localparam logic [11:0] OFF_CTRL1  = 12'h904;
    localparam logic [11:0] OFF_CTRL2  = 12'h908;
    localparam logic [11:0] OFF_BASE_L = 12'h90C;
    localparam logic [11:0] OFF_BASE_H = 12'h910;
    localparam logic [11:0] OFF_LIMIT  = 12'h914;
    localparam logic [11:0] OFF_TGT_L  = 12'h918;
    localparam logic [11:0] OFF_TGT_H  = 12'h91C;

    localparam int EN_BIT  = 31;
    localparam int DIR_BIT = 31;

    // Programmed (software-visible) window registers
    typedef struct packed {
        logic [XW_ADDR_W-1:0] base;
        logic [XW_ADDR_W-1:0] target;
        logic [XW_DATA_W-1:0] limit;
        logic [XW_DATA_W-1:0] ctrl1;
        logic [XW_DATA_W-1:0] ctrl2;
    } xw_prog_t;

    // Committed window state used by the matcher
    typedef struct packed {
        logic                 en;
        logic                 cfg;
        logic [XW_ADDR_W-1:0] base;
        logic [XW_ADDR_W-1:0] size;
    } xw_act_t;

    typedef struct packed {
        logic                 valid;
        logic                 inbound;
        logic [XW_ADDR_W-1:0] addr;
    } xw_req_t;

endpackage

// File: rtl/xwu_regfile.sv
module xwu_regfile
    import xwu_pkg::*;
#(
    parameter int NUM_WIN = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [11:0]                    addr,
    input  logic [XW_DATA_W-1:0]           wdata,
    output logic [XW_DATA_W-1:0]           rdata,
    output xw_act_t [2*NUM_WIN-1:0]        act_o,
    output logic [2*NUM_WIN-1:0][XW_ADDR_W-1:0] target_o
);

    localparam int NS     = 2 * NUM_WIN;
    localparam int SLOT_W = $clog2(NS);
    localparam logic [XW_IDX_W:0] NWIN_L = (XW_IDX_W + 1)'(NUM_WIN);

    typedef struct packed {
        logic [XW_DATA_W-1:0] view;
        xw_prog_t [NS-1:0]    prog;
        xw_act_t  [NS-1:0]    act;
    } rf_state_t;

    rf_state_t st_d, st_q;

    logic              sel_ok;
    logic [SLOT_W-1:0] sel_slot;
    logic [XW_IDX_W-1:0] sel_idx;

    function automatic rf_state_t rf_reset();
        rf_state_t s;
        s.view = '0;
        for (int i = 0; i < NS; i++) begin
            s.prog[i].base   = '0;
            s.prog[i].target = '0;
            s.prog[i].limit  = 32'hFFFF_FFFF;
            s.prog[i].ctrl1  = '0;
            s.prog[i].ctrl2  = '0;
            s.act[i].en      = 1'b0;
            s.act[i].cfg     = 1'b0;
            s.act[i].base    = '0;
            s.act[i].size    = 64'h1_0000_0000;
        end
        // inbound window 0 passes traffic by default
        s.prog[NUM_WIN].ctrl2 = 32'h8000_0000;
        s.act[NUM_WIN].en     = 1'b1;
        return s;
    endfunction

    always_comb begin
        sel_idx  = st_q.view[XW_IDX_W-1:0];
        sel_ok   = ({1'b0, sel_idx} < NWIN_L);
        sel_slot = st_q.view[DIR_BIT] ? (SLOT_W'(NUM_WIN) + SLOT_W'(sel_idx))
                                      : SLOT_W'(sel_idx);
    end

    // next-state process
    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (addr == OFF_VIEW) begin
                st_d.view = wdata;
            end else if (sel_ok) begin
                case (addr)
                    OFF_CTRL1:  st_d.prog[sel_slot].ctrl1 = wdata;
                    OFF_CTRL2: begin
                        st_d.prog[sel_slot].ctrl2 = wdata;
                        st_d.act[sel_slot].en   = wdata[EN_BIT];
                        st_d.act[sel_slot].cfg  = |st_q.prog[sel_slot].ctrl1[XW_TYPE_W-1:0];
                        st_d.act[sel_slot].base = st_q.prog[sel_slot].base;
                        st_d.act[sel_slot].size = {32'h0, st_q.prog[sel_slot].limit}
                                                - st_q.prog[sel_slot].base + 64'd1;
                    end
                    OFF_BASE_L: st_d.prog[sel_slot].base[31:0]    = wdata;
                    OFF_BASE_H: st_d.prog[sel_slot].base[63:32]   = wdata;
                    OFF_LIMIT:  st_d.prog[sel_slot].limit         = wdata;
                    OFF_TGT_L:  st_d.prog[sel_slot].target[31:0]  = wdata;
                    OFF_TGT_H:  st_d.prog[sel_slot].target[63:32] = wdata;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= rf_reset();
        else        st_q <= st_d;
    end

    // read mux
    always_comb begin
        rdata = '0;
        if (addr == OFF_VIEW) begin
            rdata = st_q.view;
        end else if (sel_ok) begin
            case (addr)
                OFF_CTRL1:  rdata = st_q.prog[sel_slot].ctrl1;
                OFF_CTRL2:  rdata = st_q.prog[sel_slot].ctrl2;
                OFF_BASE_L: rdata = st_q.prog[sel_slot].base[31:0];
                OFF_BASE_H: rdata = st_q.prog[sel_slot].base[63:32];
                OFF_LIMIT:  rdata = st_q.prog[sel_slot].limit;
                OFF_TGT_L:  rdata = st_q.prog[sel_slot].target[31:0];
                OFF_TGT_H:  rdata = st_q.prog[sel_slot].target[63:32];
                default:    rdata = '0;
            endcase
        end
    end

    assign act_o = st_q.act;

    for (genvar i = 0; i < NS; i++) begin : g_tgt
        assign target_o[i] = st_q.prog[i].target;
    end

endmodule

// File: rtl/xwu_match.sv
module xwu_match
    import xwu_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int WIN_W   = 2
) (
    input  logic                                 inbound_i,
    input  logic [XW_ADDR_W-1:0]                 addr_i,
    input  xw_act_t [2*NUM_WIN-1:0]              act_i,
    input  logic [2*NUM_WIN-1:0][XW_ADDR_W-1:0]  target_i,
    output logic                                 hit_o,
    output logic [WIN_W-1:0]                     win_o,
    output logic                                 cfg_o,
    output logic [XW_ADDR_W-1:0]                 addr_o,
    output logic [7:0]                           bus_o,
    output logic [7:0]                           devfn_o
);

    logic [NUM_WIN-1:0]                hit_vec;
    logic [NUM_WIN-1:0]                cfg_vec;
    logic [NUM_WIN-1:0][XW_ADDR_W-1:0] xl_vec;
    logic [NUM_WIN-1:0][7:0]           bus_vec;
    logic [NUM_WIN-1:0][7:0]           devfn_vec;

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        xw_act_t              a;
        logic [XW_ADDR_W-1:0] tgt;
        logic [XW_ADDR_W-1:0] off;

        assign a   = inbound_i ? act_i[NUM_WIN + w] : act_i[w];
        assign tgt = inbound_i ? target_i[NUM_WIN + w] : target_i[w];
        assign off = addr_i - a.base;

        assign hit_vec[w]   = a.en && (off < a.size);
        assign cfg_vec[w]   = a.cfg;
        assign xl_vec[w]    = a.cfg ? off : (off + tgt);
        assign bus_vec[w]   = a.cfg ? tgt[31:24] : 8'h00;
        assign devfn_vec[w] = a.cfg ? tgt[23:16] : 8'h00;
    end

    // lowest index wins: scan downward so the last assignment is the lowest
    always_comb begin
        hit_o   = 1'b0;
        win_o   = '0;
        cfg_o   = 1'b0;
        addr_o  = '0;
        bus_o   = '0;
        devfn_o = '0;
        for (int w = NUM_WIN - 1; w >= 0; w--) begin
            if (hit_vec[w]) begin
                hit_o   = 1'b1;
                win_o   = WIN_W'(w);
                cfg_o   = cfg_vec[w];
                addr_o  = xl_vec[w];
                bus_o   = bus_vec[w];
                devfn_o = devfn_vec[w];
            end
        end
    end

endmodule

// File: rtl/xwu_top.sv
module xwu_top
    import xwu_pkg::*;
#(
    parameter int NUM_WIN = 4,
    localparam int WIN_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [11:0]          reg_addr,
    input  logic [XW_DATA_W-1:0] reg_wdata,
    output logic [XW_DATA_W-1:0] reg_rdata,
    input  logic                 req_valid,
    input  logic                 req_inbound,
    input  logic [XW_ADDR_W-1:0] req_addr,
    output logic                 rsp_valid,
    output logic                 rsp_hit,
    output logic                 rsp_miss,
    output logic                 rsp_is_cfg,
    output logic [WIN_W-1:0]     rsp_win,
    output logic [XW_ADDR_W-1:0] rsp_addr,
    output logic [7:0]           rsp_bus,
    output logic [7:0]           rsp_devfn
);

    localparam int NS = 2 * NUM_WIN;

    xw_req_t req_d, req_q;

    xw_act_t [NS-1:0]                act;
    logic [NS-1:0][XW_ADDR_W-1:0]    target;

    logic                 m_hit;
    logic [WIN_W-1:0]     m_win;
    logic                 m_cfg;
    logic [XW_ADDR_W-1:0] m_addr;
    logic [7:0]           m_bus;
    logic [7:0]           m_devfn;

    xwu_regfile #(.NUM_WIN(NUM_WIN)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .act_o    (act),
        .target_o (target)
    );

    // request capture: two-process
    always_comb begin
        req_d         = req_q;
        req_d.valid   = req_valid;
        if (req_valid) begin
            req_d.inbound = req_inbound;
            req_d.addr    = req_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_d;
    end

    xwu_match #(.NUM_WIN(NUM_WIN), .WIN_W(WIN_W)) u_match (
        .inbound_i (req_q.inbound),
        .addr_i    (req_q.addr),
        .act_i     (act),
        .target_i  (target),
        .hit_o     (m_hit),
        .win_o     (m_win),
        .cfg_o     (m_cfg),
        .addr_o    (m_addr),
        .bus_o     (m_bus),
        .devfn_o   (m_devfn)
    );

    always_comb begin
        rsp_valid  = req_q.valid;
        rsp_hit    = req_q.valid && m_hit;
        rsp_miss   = req_q.valid && !m_hit;
        rsp_is_cfg = rsp_hit && m_cfg;
        rsp_win    = rsp_hit ? m_win   : '0;
        rsp_addr   = rsp_hit ? m_addr  : '0;
        rsp_bus    = rsp_hit ? m_bus   : '0;
        rsp_devfn  = rsp_hit ? m_devfn : '0;
    end

endmodule

// File: rtl/xwu_checker.sv
module xwu_checker
    import xwu_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic [11:0]          reg_addr,
    input logic [XW_DATA_W-1:0] reg_rdata,
    input logic                 req_valid,
    input logic                 rsp_valid,
    input logic                 rsp_hit,
    input logic                 rsp_miss,
    input logic                 rsp_is_cfg,
    input logic [XW_ADDR_W-1:0] rsp_addr,
    input logic [7:0]           rsp_bus,
    input logic [7:0]           rsp_devfn
);

    // R10: response follows the request by exactly one cycle
    a_r10_rsp_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rsp_valid == $past(req_valid)));

    // R9: a valid response is either a hit or a miss, never both
    a_r9_hit_xor_miss: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit != rsp_miss));

    // R9: no result flags without a response
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_hit && !rsp_miss && !rsp_is_cfg));

    // R7: configuration result only on a hit
    a_r7_cfg_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_is_cfg |-> rsp_hit);

    // R9: a miss carries zero payload
    a_r9_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (rsp_addr == '0 && rsp_bus == '0 && rsp_devfn == '0));

    // R11: offsets outside the aperture read zero
    a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr < OFF_VIEW || reg_addr > OFF_TGT_H) |-> (reg_rdata == '0));

endmodule

bind xwu_top xwu_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata),
    .req_valid  (req_valid),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_miss   (rsp_miss),
    .rsp_is_cfg (rsp_is_cfg),
    .rsp_addr   (rsp_addr),
    .rsp_bus    (rsp_bus),
    .rsp_devfn  (rsp_devfn)
);

// File: tb/tb_xwu_top.sv
module tb_xwu_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic        req_inbound = 1'b0;
    logic [63:0] req_addr = '0;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_is_cfg;
    logic [1:0]  rsp_win;
    logic [63:0] rsp_addr;
    logic [7:0]  rsp_bus, rsp_devfn;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    xwu_top dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
        .req_inbound(req_inbound), .req_addr(req_addr), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_is_cfg(rsp_is_cfg),
        .rsp_win(rsp_win), .rsp_addr(rsp_addr), .rsp_bus(rsp_bus),
        .rsp_devfn(rsp_devfn)
    );

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [11:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(tag, 64'(reg_rdata), 64'(exp));
    endtask

    task automatic sel(input logic inb, input int idx);
        wr(12'h900, {inb, 27'd0, 4'(idx)});
    endtask

    task automatic prog_win(input logic inb, input int idx, input logic [63:0] base,
                            input logic [31:0] limit, input logic [63:0] tgt,
                            input logic [31:0] c1, input logic [31:0] c2);
        sel(inb, idx);
        wr(12'h90C, base[31:0]);
        wr(12'h910, base[63:32]);
        wr(12'h914, limit);
        wr(12'h918, tgt[31:0]);
        wr(12'h91C, tgt[63:32]);
        wr(12'h904, c1);
        wr(12'h908, c2);
    endtask

    // issue one request; return at the negedge where its response is visible
    task automatic lookup(input logic inb, input logic [63:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_inbound = inb; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        #1;
    endtask

    task automatic exp_mem(input string tag, input logic inb, input logic [63:0] a,
                           input int win, input logic [63:0] xa);
        lookup(inb, a);
        check({tag, " hit"}, 64'(rsp_valid && rsp_hit && !rsp_miss && !rsp_is_cfg), 64'd1);
        check({tag, " win"}, 64'(rsp_win), 64'(win));
        check({tag, " addr"}, rsp_addr, xa);
    endtask

    task automatic exp_miss(input string tag, input logic inb, input logic [63:0] a);
        lookup(inb, a);
        check({tag, " miss"}, 64'({rsp_valid, rsp_hit, rsp_miss, rsp_is_cfg}), 64'b1010);
        check({tag, " zero"}, rsp_addr | 64'(rsp_bus) | 64'(rsp_devfn) | 64'(rsp_win), 64'd0);
    endtask

    task automatic t_reset();
        check("R10 idle after reset", 64'(rsp_valid), 64'd0);
        rd_check("R1 selector reset", 12'h900, 32'h0);
        rd_check("R3 out0 limit", 12'h914, 32'hFFFF_FFFF);
        rd_check("R3 out0 ctrl2", 12'h908, 32'h0);
        sel(1'b1, 0);
        rd_check("R1 selector readback", 12'h900, 32'h8000_0000);
        rd_check("R3 in0 ctrl2", 12'h908, 32'h8000_0000);
        rd_check("R3 in0 base", 12'h90C, 32'h0);
        exp_mem("R3 inbound default", 1'b1, 64'h1234_5678, 0, 64'h1234_5678);
        exp_miss("R3 inbound above 4G", 1'b1, 64'h1_0000_0000);
        exp_miss("R9 outbound none enabled", 1'b0, 64'h1234_5678);
    endtask

    task automatic t_mem();
        prog_win(1'b0, 1, 64'h1000_0000, 32'h1000_FFFF, 64'h5_0020_0000, 32'h0, 32'h8000_0000);
        exp_mem("R6 inside", 1'b0, 64'h1000_0010, 1, 64'h5_0020_0010);
        exp_mem("R6 last byte", 1'b0, 64'h1000_FFFF, 1, 64'h5_0020_FFFF);
        exp_miss("R6 one past limit", 1'b0, 64'h1001_0000);
        exp_miss("R6 below base", 1'b0, 64'h0FFF_FFFF);
    endtask

    task automatic t_defer();
        sel(1'b0, 1);
        wr(12'h90C, 32'h2000_0000);
        wr(12'h914, 32'h2000_FFFF);
        rd_check("R4 base readback", 12'h90C, 32'h2000_0000);
        exp_mem("R4 old range kept", 1'b0, 64'h1000_0010, 1, 64'h5_0020_0010);
        exp_miss("R4 new range inactive", 1'b0, 64'h2000_0010);
        wr(12'h908, 32'h8000_0000);
        exp_mem("R5 commit new range", 1'b0, 64'h2000_0010, 1, 64'h5_0020_0010);
        exp_miss("R5 old range gone", 1'b0, 64'h1000_0010);
    endtask

    task automatic t_cfg();
        prog_win(1'b0, 2, 64'h3000_0000, 32'h3000_0FFF, 64'h0312_0000, 32'h4, 32'h8000_0000);
        lookup(1'b0, 64'h3000_0104);
        check("R7 cfg flag", 64'({rsp_hit, rsp_is_cfg}), 64'b11);
        check("R7 bus", 64'(rsp_bus), 64'h03);
        check("R7 devfn", 64'(rsp_devfn), 64'h12);
        check("R7 offset", rsp_addr, 64'h104);
        check("R7 win", 64'(rsp_win), 64'd2);
    endtask

    task automatic t_prio();
        prog_win(1'b0, 3, 64'h4000_0000, 32'h4000_FFFF, 64'h9_0000_0000, 32'h0, 32'h8000_0000);
        exp_mem("R8 only win3", 1'b0, 64'h4000_0008, 3, 64'h9_0000_0008);
        prog_win(1'b0, 0, 64'h4000_0000, 32'h4000_00FF, 64'h1_0000_0000, 32'h0, 32'h8000_0000);
        exp_mem("R8 win0 beats win3", 1'b0, 64'h4000_0008, 0, 64'h1_0000_0008);
        exp_mem("R8 outside win0", 1'b0, 64'h4000_0100, 3, 64'h9_0000_0100);
        sel(1'b0, 0);
        wr(12'h908, 32'h0);
        rd_check("R5 ctrl2 cleared", 12'h908, 32'h0);
        exp_mem("R5 win0 disabled", 1'b0, 64'h4000_0008, 3, 64'h9_0000_0008);
    endtask

    task automatic t_unimpl();
        sel(1'b0, 5);
        rd_check("R1 selector idx5", 12'h900, 32'h5);
        wr(12'h90C, 32'hAAAA_0000);
        wr(12'h908, 32'h8000_0000);
        rd_check("R11 idx5 base reads 0", 12'h90C, 32'h0);
        rd_check("R11 idx5 limit reads 0", 12'h914, 32'h0);
        rd_check("R11 unmapped offset", 12'h800, 32'h0);
        sel(1'b0, 1);
        rd_check("R11 win1 untouched", 12'h90C, 32'h2000_0000);
        exp_miss("R11 no window at AAAA", 1'b0, 64'hAAAA_0000);
        sel(1'b1, 1);
        rd_check("R2 inbound1 separate", 12'h90C, 32'h0);
        rd_check("R2 inbound1 target hi", 12'h91C, 32'h0);
        exp_mem("R2 inbound uses in0", 1'b1, 64'h2000_0010, 0, 64'h2000_0010);
    endtask

    task automatic t_pipe();
        @(negedge clk);
        req_valid = 1'b1; req_inbound = 1'b0; req_addr = 64'h2000_0020;
        @(negedge clk);
        #1;
        check("R10 first resp", rsp_addr, 64'h5_0020_0020);
        req_valid = 1'b1; req_inbound = 1'b0; req_addr = 64'h3000_0010;
        @(negedge clk);
        #1;
        check("R10 second resp cfg", 64'({rsp_valid, rsp_is_cfg}), 64'b11);
        check("R10 second resp addr", rsp_addr, 64'h10);
        req_valid = 1'b0;
        @(negedge clk);
        #1;
        check("R10 idle after burst", 64'(rsp_valid), 64'd0);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mem();
        t_defer();
        t_cfg();
        t_prio();
        t_unimpl();
        t_pipe();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule